// File: doc/BRIEF.md
# Infrared Remote Pulse-Distance Frame Encoder

This block is the transmit half of a handheld infrared remote. It watches a key-held level. Once the press has lasted longer than a qualification window, it drives a baseband burst level. A high level means the LED should emit and a low level means it stays dark. The first transmission is a full frame: a long leading burst, a quiet gap, and then 32 data bits. The bits carry a 16-bit address, the key code, and the key code's complement. Each bit is encoded by the length of the quiet interval that follows a fixed short burst.

While the key stays down, transmissions are spaced on a fixed 108 ms grid, measured from the start of one transmission to the start of the next. After the first slot, every later slot carries only a short repeat code. An optional carrier output toggles at the carrier rate, but only while the burst level is high. A typical receiver module inverts the signal, so a high burst here shows up as a low level at the receiver's output.

All durations are derived from a clock-frequency parameter, so the same RTL serves any system clock.

Top module: `nec_ir_encoder`

## Requirements
- R1: A transmission starts only after the key has been sampled high on more than QUAL = floor(CLK_HZ*36000/1e6) consecutive clock edges. The first burst rises between QUAL+1 and QUAL+3 cycles after the key rises. A key held for QUAL edges or fewer, then released, produces no burst.
- R2: A full frame opens with a burst of floor(CLK_HZ*9000/1e6) ticks, followed by a quiet gap of floor(CLK_HZ*4500/1e6) ticks, each within one tick.
- R3: The 32 payload bits of a full frame go out in this order: address bits 7:0, address bits 15:8, the key code, then the bitwise complement of the key code. Each byte is sent least significant bit first. Address and key code are captured when the frame starts.
- R4: Every payload bit is a burst of M = floor(CLK_HZ*560/1e6) ticks. It is followed by a quiet interval of floor(CLK_HZ*1125/1e6)-M ticks for a 0, or floor(CLK_HZ*2250/1e6)-M ticks for a 1, each within one tick.
- R5: While the key stays held, successive transmissions start exactly floor(CLK_HZ*108000/1e6) cycles apart, measured burst start to burst start.
- R6: Every transmission after the first while the key stays held is a repeat code. It is a header-length burst followed by a quiet gap of floor(CLK_HZ*2500/1e6) ticks, with no payload.
- R7: Every full frame and every repeat code ends with one trailing burst of M ticks.
- R8: A release does not cut short a transmission already in progress. After a release, no further burst starts until the key is qualified again.
- R9: The busy output is high from the first cycle of the leading burst through the last cycle of the trailing burst. It is low once the trailing burst ends.
- R10: The carrier output is never high while the burst level is low. During a burst it toggles every floor(CLK_HZ/(2*CARRIER_HZ)) cycles, so a header burst holds floor(HDR/(2*half)) carrier rising edges, within one.
- R11: After reset, the burst, carrier and busy outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| key_held_i | input | 1 | High while a key is pressed |
| key_code_i | input | 8 | Code of the pressed key |
| addr_i | input | 16 | Device address to transmit |
| burst_o | output | 1 | Baseband level, high during a burst |
| carrier_o | output | 1 | Burst level gated with the carrier square wave |
| busy_o | output | 1 | High from leading burst start to trailing burst end |

## Verification
The bench releases the key one edge before qualification and checks that no burst appears, since an off-by-one counter would send a stray frame. It releases the key in the middle of the longest payload (all ones) and checks that the frame still ends cleanly and that no repeat follows; a design that aborted would leave a truncated frame, and one that ignored the release would keep sending repeat codes. It holds the key across several slots to catch a design that never switches to repeat codes or that drifts off the 108 ms grid. Randomized address and key values, together with the all-zero and all-one payloads, expose a wrong byte order or a wrong bit order.

// File: rtl/nec_tx_pkg.sv
package nec_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_GAP,
    ST_BMARK,
    ST_BSPACE,
    ST_TAIL,
    ST_WAIT
  } nec_state_e;

  localparam int unsigned PAYLOAD_BITS = 32;

  // Convert a duration in microseconds to clock ticks (floor).
  function automatic int unsigned us_to_ticks(input longint unsigned clk_hz,
                                              input longint unsigned us);
    longint unsigned t;
    t = (clk_hz * us) / 64'd1000000;
    return 32'(t);
  endfunction

  function automatic logic is_mark(input nec_state_e s);
    return (s == ST_HDR) || (s == ST_BMARK) || (s == ST_TAIL);
  endfunction

  function automatic logic is_busy(input nec_state_e s);
    return (s != ST_IDLE) && (s != ST_WAIT);
  endfunction

endpackage

// File: rtl/nec_hold_qual.sv
module nec_hold_qual #(
  parameter int unsigned QUAL_T = 1440,
  localparam int unsigned QW = $clog2(QUAL_T + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic key_i,
  output logic qual_o
);

  logic [QW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      qual_o   <= 1'b0;
    end else if (!key_i) begin
      hold_cnt <= '0;
      qual_o   <= 1'b0;
    end else begin
      if (hold_cnt != QW'(QUAL_T)) hold_cnt <= hold_cnt + 1'b1;
      qual_o <= (hold_cnt == QW'(QUAL_T));
    end
  end

  AST_QUAL_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    qual_o |-> $past(key_i)); // R1

endmodule

// File: rtl/nec_carrier_gen.sv
module nec_carrier_gen #(
  parameter bit          ENABLE = 1'b1,
  parameter int unsigned HALF_T = 10,
  localparam int unsigned HW = $clog2(HALF_T + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic mark_next_i,
  output logic carrier_o
);

  generate
    if (ENABLE) begin : g_carrier
      logic [HW-1:0] phase_cnt;
      logic          car_q;

      always_ff @(posedge clk) begin
        if (rst || !mark_next_i) begin
          phase_cnt <= '0;
          car_q     <= 1'b0;
        end else if (phase_cnt == HW'(HALF_T - 1)) begin
          phase_cnt <= '0;
          car_q     <= ~car_q;
        end else begin
          phase_cnt <= phase_cnt + 1'b1;
        end
      end

      assign carrier_o = car_q;
    end else begin : g_no_carrier
      logic unused_in;
      assign unused_in = clk ^ rst ^ mark_next_i;
      assign carrier_o = 1'b0 & unused_in;
    end
  endgenerate

endmodule

// File: rtl/nec_frame_seq.sv
module nec_frame_seq
  import nec_tx_pkg::*;
#(
  parameter int unsigned HDR_T    = 360,
  parameter int unsigned GAP_T    = 180,
  parameter int unsigned RGAP_T   = 100,
  parameter int unsigned MARK_T   = 22,
  parameter int unsigned Q0_T     = 23,
  parameter int unsigned Q1_T     = 68,
  parameter int unsigned PERIOD_T = 4320,
  localparam int unsigned CW = $clog2(PERIOD_T + 1),
  localparam int unsigned BW = $clog2(PAYLOAD_BITS)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        key_i,
  input  logic        qual_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  code_i,
  output logic        mark_o,
  output logic        mark_next_o,
  output logic        busy_o
);

  nec_state_e                state_q, state_n;
  logic [CW-1:0]             seg_cnt;
  logic [CW-1:0]             per_cnt;
  logic [BW-1:0]             bit_idx;
  logic [PAYLOAD_BITS-1:0]   word_q;
  logic                      rpt_q;
  logic                      rel_q;
  logic                      seg_load;
  logic [CW-1:0]             seg_len;
  logic                      seg_done;
  logic                      slot_end;
  logic                      cur_bit;

  assign seg_done = (seg_cnt == '0);
  assign slot_end = (per_cnt == CW'(PERIOD_T - 1));
  assign cur_bit  = word_q[bit_idx];

  always_comb begin
    state_n  = state_q;
    seg_load = 1'b0;
    seg_len  = CW'(MARK_T);
    unique case (state_q)
      ST_IDLE: begin
        if (qual_i && key_i) begin
          state_n  = ST_HDR;
          seg_load = 1'b1;
          seg_len  = CW'(HDR_T);
        end
      end
      ST_HDR: begin
        if (seg_done) begin
          state_n  = ST_GAP;
          seg_load = 1'b1;
          seg_len  = rpt_q ? CW'(RGAP_T) : CW'(GAP_T);
        end
      end
      ST_GAP: begin
        if (seg_done) begin
          state_n  = rpt_q ? ST_TAIL : ST_BMARK;
          seg_load = 1'b1;
          seg_len  = CW'(MARK_T);
        end
      end
      ST_BMARK: begin
        if (seg_done) begin
          state_n  = ST_BSPACE;
          seg_load = 1'b1;
          seg_len  = cur_bit ? CW'(Q1_T) : CW'(Q0_T);
        end
      end
      ST_BSPACE: begin
        if (seg_done) begin
          state_n  = (bit_idx == BW'(PAYLOAD_BITS - 1)) ? ST_TAIL : ST_BMARK;
          seg_load = 1'b1;
          seg_len  = CW'(MARK_T);
        end
      end
      ST_TAIL: begin
        if (seg_done) state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (slot_end) begin
          if (rel_q || !key_i) begin
            state_n = ST_IDLE;
          end else begin
            state_n  = ST_HDR;
            seg_load = 1'b1;
            seg_len  = CW'(HDR_T);
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign mark_next_o = is_mark(state_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      seg_cnt <= '0;
      per_cnt <= '0;
      bit_idx <= '0;
      word_q  <= '0;
      rpt_q   <= 1'b0;
      rel_q   <= 1'b0;
      mark_o  <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      state_q <= state_n;
      mark_o  <= is_mark(state_n);
      busy_o  <= is_busy(state_n);

      if (seg_load)      seg_cnt <= seg_len - 1'b1;
      else if (!seg_done) seg_cnt <= seg_cnt - 1'b1;

      if (state_n == ST_HDR && state_q != ST_HDR) per_cnt <= '0;
      else if (state_q != ST_IDLE)                per_cnt <= per_cnt + 1'b1;

      if (state_q == ST_IDLE && state_n == ST_HDR) begin
        word_q <= {~code_i, code_i, addr_i[15:8], addr_i[7:0]};
        rpt_q  <= 1'b0;
      end else if (state_q == ST_WAIT && state_n == ST_HDR) begin
        rpt_q  <= 1'b1;
      end

      if (state_n == ST_HDR && state_q != ST_HDR)    bit_idx <= '0;
      else if (state_q == ST_BSPACE && seg_done)     bit_idx <= bit_idx + 1'b1;

      if (state_q == ST_IDLE) rel_q <= 1'b0;
      else if (!key_i)        rel_q <= 1'b1;
    end
  end

  AST_MARK_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mark_o |-> busy_o); // R9

  AST_FRAME_FITS_SLOT: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && state_q != ST_WAIT) |-> (per_cnt < CW'(PERIOD_T))); // R5

  AST_START_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(key_i)); // R8

  AST_NO_REPEAT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && rel_q) |=> (state_q != ST_HDR)); // R8

  AST_REPEAT_HAS_NO_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    rpt_q |-> (state_q != ST_BMARK && state_q != ST_BSPACE)); // R6

endmodule

// File: rtl/nec_ir_encoder.sv
module nec_ir_encoder
  import nec_tx_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 50_000_000,
  parameter longint unsigned CARRIER_HZ = 38_000,
  parameter bit              CARRIER_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        key_held_i,
  input  logic [7:0]  key_code_i,
  input  logic [15:0] addr_i,
  output logic        burst_o,
  output logic        carrier_o,
  output logic        busy_o
);

  localparam int unsigned QUAL_T   = us_to_ticks(CLK_HZ, 36000);
  localparam int unsigned HDR_T    = us_to_ticks(CLK_HZ, 9000);
  localparam int unsigned GAP_T    = us_to_ticks(CLK_HZ, 4500);
  localparam int unsigned RGAP_T   = us_to_ticks(CLK_HZ, 2500);
  localparam int unsigned MARK_T   = us_to_ticks(CLK_HZ, 560);
  localparam int unsigned Q0_T     = us_to_ticks(CLK_HZ, 1125) - MARK_T;
  localparam int unsigned Q1_T     = us_to_ticks(CLK_HZ, 2250) - MARK_T;
  localparam int unsigned PERIOD_T = us_to_ticks(CLK_HZ, 108000);
  localparam longint unsigned HALF_RAW = CLK_HZ / (2 * CARRIER_HZ);
  localparam int unsigned HALF_T   = (HALF_RAW < 1) ? 1 : 32'(HALF_RAW);

  logic qual;
  logic mark_next;

  nec_hold_qual #(
    .QUAL_T(QUAL_T)
  ) u_qual (
    .clk    (clk),
    .rst    (rst),
    .key_i  (key_held_i),
    .qual_o (qual)
  );

  nec_frame_seq #(
    .HDR_T   (HDR_T),
    .GAP_T   (GAP_T),
    .RGAP_T  (RGAP_T),
    .MARK_T  (MARK_T),
    .Q0_T    (Q0_T),
    .Q1_T    (Q1_T),
    .PERIOD_T(PERIOD_T)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .key_i       (key_held_i),
    .qual_i      (qual),
    .addr_i      (addr_i),
    .code_i      (key_code_i),
    .mark_o      (burst_o),
    .mark_next_o (mark_next),
    .busy_o      (busy_o)
  );

  nec_carrier_gen #(
    .ENABLE(CARRIER_EN),
    .HALF_T(HALF_T)
  ) u_car (
    .clk        (clk),
    .rst        (rst),
    .mark_next_i(mark_next),
    .carrier_o  (carrier_o)
  );

  AST_CARRIER_GATED: assert property (@(posedge clk) disable iff (rst)
    carrier_o |-> burst_o); // R10

  AST_BUSY_LOW_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!busy_o && !burst_o)); // R11

endmodule

// File: tb/tb_nec_ir_encoder.sv
module tb_nec_ir_encoder;

  localparam longint unsigned CLK_HZ     = 40_000;
  localparam longint unsigned CARRIER_HZ = 2_000;
  localparam int WD_LIMIT = 190_000;

  function automatic int tk(input longint unsigned us);
    return int'((CLK_HZ * us) / 1000000);
  endfunction

  localparam int QUAL   = tk(36000);
  localparam int HDR    = tk(9000);
  localparam int GAP    = tk(4500);
  localparam int RGAP   = tk(2500);
  localparam int MARK   = tk(560);
  localparam int Q0     = tk(1125) - tk(560);
  localparam int Q1     = tk(2250) - tk(560);
  localparam int PERIOD = tk(108000);
  localparam int HALF   = int'(CLK_HZ / (2 * CARRIER_HZ));

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key = 1'b0;
  logic [7:0]  code = '0;
  logic [15:0] addr = '0;
  logic        burst, carrier, busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int car_viol = 0;

  nec_ir_encoder #(
    .CLK_HZ(CLK_HZ), .CARRIER_HZ(CARRIER_HZ), .CARRIER_EN(1'b1)
  ) dut (
    .clk(clk), .rst(rst), .key_held_i(key), .key_code_i(code),
    .addr_i(addr), .burst_o(burst), .carrier_o(carrier), .busy_o(busy)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) if (!rst && carrier && !burst) car_viol++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit near(input int a, input int b);
    return (a - b <= 1) && (b - a <= 1);
  endfunction

  function automatic logic [31:0] exp_word(input logic [15:0] a, input logic [7:0] k);
    return {~k, k, a[15:8], a[7:0]};
  endfunction

  task automatic run_len(input logic lvl, output int n, output int rises);
    logic pc;
    n = 0; rises = 0; pc = carrier;
    while (burst === lvl && n < 20000) begin
      n++;
      @(negedge clk);
      if (carrier && !pc) rises++;
      pc = carrier;
    end
  endtask

  task automatic wait_burst(input int lim, output int w);
    w = 0;
    while (burst !== 1'b1 && w < lim) begin
      @(negedge clk);
      w++;
    end
  endtask

  // Called at a negedge where burst has just been seen high.
  task automatic check_frame(input bit full, input logic [15:0] a, input logic [7:0] k);
    int n, r, s;
    logic [31:0] word, ew;
    chk(busy === 1'b1, "R9 busy at leading burst", busy, 1);
    run_len(1'b1, n, r);
    chk(near(n, HDR), full ? "R2 header burst" : "R6 repeat burst", n, HDR);
    chk((r >= HDR / (2 * HALF) - 1) && (r <= HDR / (2 * HALF) + 1), "R10 carrier rises", r, HDR / (2 * HALF));
    run_len(1'b0, n, r);
    if (full) chk(near(n, GAP), "R2 header gap", n, GAP);
    else      chk(near(n, RGAP), "R6 repeat gap", n, RGAP);
    if (full) begin
      ew = exp_word(a, k);
      word = '0;
      for (int i = 0; i < 32; i++) begin
        run_len(1'b1, n, r);
        chk(near(n, MARK), "R4 bit burst", n, MARK);
        run_len(1'b0, s, r);
        word[i] = (s > (Q0 + Q1) / 2);
        chk(near(s, ew[i] ? Q1 : Q0), "R4 bit quiet", s, ew[i] ? Q1 : Q0);
      end
      chk(word == ew, "R3 payload order", word, ew);
    end
    run_len(1'b1, n, r);
    chk(near(n, MARK), "R7 trailing burst", n, MARK);
    chk(busy === 1'b0, "R9 busy after trailing burst", busy, 0);
  endtask

  task automatic press(input logic [15:0] a, input logic [7:0] k);
    addr = a; code = k; key = 1'b1;
  endtask

  task automatic expect_silence(input int len, input string req);
    int w;
    wait_burst(len, w);
    chk(burst !== 1'b1, req, burst, 0);
  endtask

  task automatic single_frame(input logic [15:0] a, input logic [7:0] k);
    int w;
    press(a, k);
    wait_burst(QUAL + 20, w);
    chk(w >= QUAL + 1 && w <= QUAL + 3, "R1 start latency", w, QUAL + 2);
    check_frame(1'b1, a, k);
    key = 1'b0;
    expect_silence(PERIOD + 50, "R8 no frame after release");
    chk(busy === 1'b0, "R9 idle busy", busy, 0);
  endtask

  initial begin
    int w, t0, t1;
    logic [15:0] ra;
    logic [7:0]  rk;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(burst === 1'b0 && busy === 1'b0 && carrier === 1'b0, "R11 reset state",
        {burst, busy, carrier}, 0);

    // Held exactly QUAL edges: too short.
    press(16'h1234, 8'h56);
    repeat (QUAL) @(negedge clk);
    key = 1'b0;
    expect_silence(2000, "R1 short press ignored");

    // Held across several slots: full frame then repeat codes.
    press(16'hA55A, 8'h3C);
    wait_burst(QUAL + 20, w);
    chk(w >= QUAL + 1 && w <= QUAL + 3, "R1 start latency", w, QUAL + 2);
    t0 = cyc;
    check_frame(1'b1, 16'hA55A, 8'h3C);
    for (int rp = 0; rp < 2; rp++) begin
      wait_burst(PERIOD + 20, w);
      t1 = cyc;
      chk(t1 - t0 == PERIOD, "R5 slot period", t1 - t0, PERIOD);
      t0 = t1;
      check_frame(1'b0, 16'hA55A, 8'h3C);
    end
    key = 1'b0;
    expect_silence(PERIOD + 50, "R8 no repeat after release");

    // Release in the middle of the longest payload.
    press(16'hFFFF, 8'hFF);
    wait_burst(QUAL + 20, w);
    fork
      check_frame(1'b1, 16'hFFFF, 8'hFF);
      begin repeat (1200) @(negedge clk); key = 1'b0; end
    join
    expect_silence(PERIOD + 50, "R8 no repeat after mid-frame release");

    single_frame(16'h0000, 8'h00);
    single_frame(16'h00FF, 8'h80);

    for (int it = 0; it < 6; it++) begin
      ra = 16'($urandom());
      rk = 8'($urandom());
      repeat (1 + ($urandom() % 50)) @(negedge clk);
      single_frame(ra, rk);
    end

    chk(car_viol == 0, "R10 carrier while quiet", car_viol, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule